// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block finishes an I2C transfer on the master side by placing a stop condition on the bus. Software requests a stop with a one-cycle strobe after the last data or acknowledge bit has completed and the clock line is low. The sequencer then pulls the data line low and keeps the clock line low. It releases the clock line after one baud period. One baud period after the clock is seen high, it releases the data line. The length of each period comes from a reloadable countdown timer whose reload value is a port.

Each phase moves on only when the sampled line level matches the level being driven. As a result, a slave that holds the clock line low stretches the sequence. A line monitor watches both lines for start and stop conditions. It keeps a start-detected flag and a stop-detected flag, and the bus counts as busy between a start and the next stop. The stop sequence ends one baud period after the stop is seen on the bus. At that point the request bit clears itself and a sticky interrupt flag is raised.

While a stop is in progress, the block protects a transmit holding register. Writes to it are refused and a sticky collision flag is set.

Top module: `i2c_stop_seq`

## Requirements
- R1: After a synchronous active-high reset, both line drives are released (`sda_drive_low`=0, `scl_drive_low`=0), `stop_en`, `start_flag`, `stop_flag`, `bus_busy`, `irq_flag` and `wcol_flag` are 0, and `tx_buf` is 0.
- R2: A `stop_wr` strobe while idle sets `stop_en` at the next clock edge. From that edge both `sda_drive_low` and `scl_drive_low` are 1.
- R3: The baud timer is reloaded with `baud_reload` (N) at the first edge where `sda_in` is sampled low. A baud period lasts N+1 clocks. With no stretching, `scl_drive_low` falls at the edge N+2 cycles after the edge that took `stop_wr`.
- R4: After SCL is released, the timer is reloaded only at an edge where `scl_in` is sampled high. Each cycle a slave holds SCL low delays all later events by one cycle, and SDA stays driven low in the meantime.
- R5: `sda_drive_low` falls N+1 cycles after the edge at which `scl_in` was first sampled high. With S stretch cycles, this is edge 2N+4+S counted from the `stop_wr` edge. SCL is already released when SDA is released.
- R6: A stop condition is SDA going from low to high on consecutive samples while SCL is high on both samples. It sets `stop_flag` and clears `start_flag` at the next edge. A start condition is SDA going from high to low while SCL is high on both samples. It sets `start_flag` and clears `stop_flag`. `bus_busy` equals `start_flag`. The two flags are never both set.
- R7: One baud period after the stop is detected, `stop_en` clears and `irq_flag` is set. This is edge 3N+6+S counted from the `stop_wr` edge.
- R8: A `buf_wr` while `stop_en` is 1 sets `wcol_flag` and leaves `tx_buf` unchanged. A `buf_wr` while `stop_en` is 0 loads `buf_wdata` into `tx_buf` at the next edge.
- R9: `irq_flag` and `wcol_flag` stay set until their clear input (`irq_clr`, `wcol_clr`) is sampled high. A clear in the same cycle as a setting event leaves the flag at 0.
- R10: A reset in the middle of a stop sequence returns the block to idle at the next edge, with both lines released and `stop_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_wr | input | 1 | Software strobe that sets the stop request |
| baud_reload | input | BAUD_W | Baud timer reload value N (period N+1 clocks) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| buf_wr | input | 1 | Transmit holding register write strobe |
| buf_wdata | input | DATA_W | Data for the transmit holding register |
| irq_clr | input | 1 | Clears the interrupt flag (wins over a set) |
| wcol_clr | input | 1 | Clears the write-collision flag (wins over a set) |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| stop_en | output | 1 | Stop request in progress, cleared by hardware |
| start_flag | output | 1 | Start condition detected last |
| stop_flag | output | 1 | Stop condition detected last |
| bus_busy | output | 1 | Bus held between a start and a stop |
| irq_flag | output | 1 | Sticky stop-complete interrupt flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| tx_buf | output | DATA_W | Transmit holding register contents |

## Verification
The assertions assume the bus behaves like a wired-AND. Whenever the block pulls a line low, that line reads low in the same cycle. A released line reads high unless a slave holds it. No other device changes SDA while the block is stepping through a stop.

The bench keeps to these assumptions. It builds each line as the AND of the block's release and a slave-side release. Slave activity is confined to three cases:
- holding SCL low for a counted number of cycles after the block releases it;
- pulling SDA low while SCL is high, to create a start condition;
- letting SDA go only after it has pulled SCL low, so that no accidental stop is seen.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SDA_LO  = 3'd1,
        PH_SCL_LO  = 3'd2,
        PH_SCL_REL = 3'd3,
        PH_SCL_HI  = 3'd4,
        PH_SDA_REL = 3'd5,
        PH_TAIL    = 3'd6
    } phase_e;

    typedef struct packed {
        logic sda_low;
        logic scl_low;
    } drive_t;

    typedef struct packed {
        logic start_evt;
        logic stop_evt;
    } line_evt_t;

    // Which lines each phase pulls low.
    function automatic drive_t phase_drive(phase_e p);
        drive_t d;
        d.sda_low = 1'b0;
        d.scl_low = 1'b0;
        case (p)
            PH_SDA_LO, PH_SCL_LO: begin
                d.sda_low = 1'b1;
                d.scl_low = 1'b1;
            end
            PH_SCL_REL, PH_SCL_HI: d.sda_low = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon
    import i2c_stop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sda_in,
    input  logic      scl_in,
    output line_evt_t evt,
    output logic      start_flag,
    output logic      stop_flag
);
    logic sda_q, scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
        end
    end

    // Conditions are only recognised with SCL high on both samples.
    always_comb begin
        evt.stop_evt  = scl_in & scl_q & sda_in & ~sda_q;
        evt.start_evt = scl_in & scl_q & ~sda_in & sda_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
        end else if (evt.stop_evt) begin
            stop_flag  <= 1'b1;
            start_flag <= 1'b0;
        end else if (evt.start_evt) begin
            start_flag <= 1'b1;
            stop_flag  <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BAUD_W-1:0] load_val,
    output logic              done
);
    logic [BAUD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end
endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
    import i2c_stop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stop_wr,
    input  logic   sda_in,
    input  logic   scl_in,
    input  logic   stop_evt,
    input  logic   tmr_done,
    output logic   tmr_load,
    output logic   irq_set,
    output logic   busy,
    output drive_t drv
);
    phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        irq_set  = 1'b0;
        case (phase_q)
            PH_IDLE:
                if (stop_wr) phase_d = PH_SDA_LO;
            PH_SDA_LO:
                if (!sda_in) begin
                    tmr_load = 1'b1;
                    phase_d  = PH_SCL_LO;
                end
            PH_SCL_LO:
                if (tmr_done) phase_d = PH_SCL_REL;
            PH_SCL_REL:
                if (scl_in) begin
                    tmr_load = 1'b1;
                    phase_d  = PH_SCL_HI;
                end
            PH_SCL_HI:
                if (tmr_done) phase_d = PH_SDA_REL;
            PH_SDA_REL:
                if (stop_evt) begin
                    tmr_load = 1'b1;
                    phase_d  = PH_TAIL;
                end
            PH_TAIL:
                if (tmr_done) begin
                    irq_set = 1'b1;
                    phase_d = PH_IDLE;
                end
            default:
                phase_d = PH_IDLE;
        endcase
    end

    assign busy = (phase_q != PH_IDLE);
    assign drv  = phase_drive(phase_q);
endmodule

// File: rtl/i2c_tx_guard.sv
module i2c_tx_guard #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              wcol_clr,
    output logic [DATA_W-1:0] tx_buf,
    output logic              wcol_flag
);
    logic collide;

    assign collide = buf_wr & busy;

    always_ff @(posedge clk) begin
        if (rst)
            tx_buf <= '0;
        else if (buf_wr && !busy)
            tx_buf <= buf_wdata;
    end

    i2c_sticky_flag u_wcol (
        .clk (clk),
        .rst (rst),
        .set (collide),
        .clr (wcol_clr),
        .q   (wcol_flag)
    );
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
    import i2c_stop_pkg::*;
#(
    parameter int BAUD_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_wr,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    output logic              sda_drive_low,
    output logic              scl_drive_low,
    output logic              stop_en,
    output logic              start_flag,
    output logic              stop_flag,
    output logic              bus_busy,
    output logic              irq_flag,
    output logic              wcol_flag,
    output logic [DATA_W-1:0] tx_buf
);
    line_evt_t evt;
    drive_t    drv;
    logic      tmr_load, tmr_done, irq_set;

    i2c_line_mon u_mon (
        .clk        (clk),
        .rst        (rst),
        .sda_in     (sda_in),
        .scl_in     (scl_in),
        .evt        (evt),
        .start_flag (start_flag),
        .stop_flag  (stop_flag)
    );

    i2c_baud_timer #(.BAUD_W(BAUD_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (baud_reload),
        .done     (tmr_done)
    );

    i2c_stop_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stop_wr  (stop_wr),
        .sda_in   (sda_in),
        .scl_in   (scl_in),
        .stop_evt (evt.stop_evt),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .irq_set  (irq_set),
        .busy     (stop_en),
        .drv      (drv)
    );

    i2c_sticky_flag u_irq (
        .clk (clk),
        .rst (rst),
        .set (irq_set),
        .clr (irq_clr),
        .q   (irq_flag)
    );

    i2c_tx_guard #(.DATA_W(DATA_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .busy      (stop_en),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .wcol_clr  (wcol_clr),
        .tx_buf    (tx_buf),
        .wcol_flag (wcol_flag)
    );

    assign sda_drive_low = drv.sda_low;
    assign scl_drive_low = drv.scl_low;
    assign bus_busy      = start_flag;
endmodule

// File: rtl/i2c_stop_seq_chk.sv
module i2c_stop_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_en,
    input logic              sda_drive_low,
    input logic              scl_drive_low,
    input logic              scl_in,
    input logic              buf_wr,
    input logic [DATA_W-1:0] tx_buf,
    input logic              wcol_flag,
    input logic              wcol_clr,
    input logic              irq_flag,
    input logic              irq_clr,
    input logic              start_flag,
    input logic              stop_flag
);
    p_scl_under_sda_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_drive_low) && !$past(rst)) |-> sda_drive_low);

    p_stretch_holds_sda_r4: assert property (@(posedge clk) disable iff (rst)
        (!scl_drive_low && sda_drive_low && !scl_in) |=> sda_drive_low);

    p_sda_after_scl_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(sda_drive_low) && !$past(rst)) |-> !scl_drive_low);

    p_cond_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(start_flag && stop_flag));

    p_irq_on_finish_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(stop_en) && !$past(rst) && !$past(irq_clr)) |-> irq_flag);

    p_buf_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && stop_en) |=> $stable(tx_buf));

    p_wcol_set_r8: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && stop_en && !wcol_clr) |=> wcol_flag);

    p_wcol_clr_wins_r9: assert property (@(posedge clk) disable iff (rst)
        wcol_clr |=> !wcol_flag);

    p_irq_clr_wins_r9: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq_flag);
endmodule

bind i2c_stop_seq i2c_stop_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .stop_en       (stop_en),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low),
    .scl_in        (scl_in),
    .buf_wr        (buf_wr),
    .tx_buf        (tx_buf),
    .wcol_flag     (wcol_flag),
    .wcol_clr      (wcol_clr),
    .irq_flag      (irq_flag),
    .irq_clr       (irq_clr),
    .start_flag    (start_flag),
    .stop_flag     (stop_flag)
);

// File: tb/i2c_stop_seq_tb.sv
`timescale 1ns/1ps
module i2c_stop_seq_tb;
    localparam int BAUD_W = 8;
    localparam int DATA_W = 8;
    localparam int NV = 5;
    // {reload N, stretch S, expected irq cycle 3N+6+S}
    localparam int VEC [NV][3] = '{
        '{0, 0, 6}, '{1, 0, 9}, '{3, 0, 15}, '{5, 2, 23}, '{2, 4, 16}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_wr = 1'b0;
    logic [BAUD_W-1:0] baud_reload = '0;
    logic buf_wr = 1'b0;
    logic [DATA_W-1:0] buf_wdata = '0;
    logic irq_clr = 1'b0, wcol_clr = 1'b0;
    logic slave_sda = 1'b0, slave_hold = 1'b0;
    logic sda_in, scl_in;
    logic sda_drive_low, scl_drive_low, stop_en, start_flag, stop_flag;
    logic bus_busy, irq_flag, wcol_flag;
    logic [DATA_W-1:0] tx_buf;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    assign sda_in = ~(sda_drive_low | slave_sda);
    assign scl_in = ~(scl_drive_low | slave_hold);

    i2c_stop_seq #(.BAUD_W(BAUD_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .stop_wr(stop_wr), .baud_reload(baud_reload),
        .sda_in(sda_in), .scl_in(scl_in), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .irq_clr(irq_clr), .wcol_clr(wcol_clr),
        .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
        .stop_en(stop_en), .start_flag(start_flag), .stop_flag(stop_flag),
        .bus_busy(bus_busy), .irq_flag(irq_flag), .wcol_flag(wcol_flag),
        .tx_buf(tx_buf)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic make_start();
        @(negedge clk) slave_sda = 1'b1;
        @(negedge clk);
        @(negedge clk) slave_hold = 1'b1;
        @(negedge clk) slave_sda = 1'b0;
        @(negedge clk);
        check("R6 start_flag after start", start_flag, 1);
        check("R6 bus_busy after start", bus_busy, 1);
        check("R6 stop_flag cleared by start", stop_flag, 0);
    endtask

    task automatic run_stop(input int n, input int s, input int exp_irq);
        int t_scl = -1, t_sda = -1, t_stop = -1, t_irq = -1;
        @(negedge clk);
        baud_reload = BAUD_W'(n);
        stop_wr = 1'b1;
        slave_hold = (s > 0);
        @(negedge clk) stop_wr = 1'b0;
        check("R2 stop_en set", stop_en, 1);
        check("R2 sda driven low", sda_drive_low, 1);
        check("R2 scl driven low", scl_drive_low, 1);
        for (int k = 0; k < 2000 && t_irq < 0; k++) begin
            if (k > 0) @(negedge clk);
            if (s > 0 && k == n + 2 + s) slave_hold = 1'b0;
            if (t_scl < 0 && !scl_drive_low) t_scl = k;
            if (t_sda < 0 && !sda_drive_low) t_sda = k;
            if (t_stop < 0 && stop_flag) t_stop = k;
            if (t_irq < 0 && irq_flag) t_irq = k;
        end
        check("R3 scl release cycle", t_scl, n + 2);
        if (s > 0) check("R4 stretched sda release cycle", t_sda, 2*n + 4 + s);
        else       check("R5 sda release cycle", t_sda, 2*n + 4);
        check("R6 stop_flag cycle", t_stop, 2*n + 5 + s);
        check("R7 irq cycle", t_irq, exp_irq);
        check("R7 stop_en cleared", stop_en, 0);
        check("R6 bus free after stop", bus_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 sda released", sda_drive_low, 0);
        check("R1 scl released", scl_drive_low, 0);
        check("R1 stop_en", stop_en, 0);
        check("R1 flags", {start_flag, stop_flag, bus_busy, irq_flag, wcol_flag}, 0);
        check("R1 tx_buf", tx_buf, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            make_start();
            run_stop(VEC[v][0], VEC[v][1], VEC[v][2]);
            repeat (4) @(negedge clk);
            check("R9 irq sticky", irq_flag, 1);
            irq_clr = 1'b1;
            @(negedge clk) irq_clr = 1'b0;
            check("R9 irq cleared", irq_flag, 0);
        end

        // R8 write while idle loads
        @(negedge clk) begin buf_wr = 1'b1; buf_wdata = 8'hA5; end
        @(negedge clk) buf_wr = 1'b0;
        check("R8 idle write loads", tx_buf, 8'hA5);

        // Collision and clear-priority run, N=10 (irq at cycle 36)
        @(negedge clk) begin baud_reload = 8'd10; stop_wr = 1'b1; end
        for (int k = 0; k <= 36; k++) begin
            @(negedge clk);
            stop_wr = 1'b0;
            case (k)
                0: begin buf_wr = 1'b1; buf_wdata = 8'h3C; end
                1: begin
                    buf_wr = 1'b0;
                    check("R8 wcol on busy write", wcol_flag, 1);
                    check("R8 tx_buf unchanged", tx_buf, 8'hA5);
                    buf_wr = 1'b1; wcol_clr = 1'b1; buf_wdata = 8'h77;
                end
                2: begin
                    buf_wr = 1'b0; wcol_clr = 1'b0;
                    check("R9 wcol clear wins", wcol_flag, 0);
                    check("R8 tx_buf still unchanged", tx_buf, 8'hA5);
                    buf_wr = 1'b1;
                end
                3: buf_wr = 1'b0;
                8: begin
                    check("R9 wcol sticky", wcol_flag, 1);
                    wcol_clr = 1'b1;
                end
                9: begin
                    wcol_clr = 1'b0;
                    check("R9 wcol cleared", wcol_flag, 0);
                end
                35: irq_clr = 1'b1;
                36: begin
                    irq_clr = 1'b0;
                    check("R9 irq clear wins over set", irq_flag, 0);
                    check("R7 stop_en cleared", stop_en, 0);
                end
                default: ;
            endcase
        end
        @(negedge clk) begin buf_wr = 1'b1; buf_wdata = 8'h11; end
        @(negedge clk) buf_wr = 1'b0;
        check("R8 write after stop loads", tx_buf, 8'h11);

        // R10 reset mid-sequence
        @(negedge clk) begin baud_reload = 8'd5; stop_wr = 1'b1; end
        @(negedge clk) stop_wr = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 busy before reset", stop_en, 1);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R10 sda released", sda_drive_low, 0);
        check("R10 scl released", scl_drive_low, 0);
        check("R10 stop_en cleared", stop_en, 0);
        check("R10 flags cleared", {irq_flag, wcol_flag, start_flag, stop_flag}, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule